// File: doc/BRIEF.md
# Timer-Woken Deep Halt Controller

This block parks a small processor core in a deep halt state and brings it back out. Software asks for the halt by strobing a halt-request write. The controller first asks the peripherals to stop. Once they acknowledge, it stops the CPU and the watchdog. While halted, the block watches a slow time-base timer source clock. If the timer is enabled, a falling edge of that clock ends the halt.

On exit, the block clears the halt bit by itself and gives one cycle of resume indication. The resume indication says whether the core must take the timer interrupt or simply continue with the next instruction. That choice comes from the global and per-timer interrupt enables. If the timer is enabled at release, the block also pulses a set into the timer interrupt latch. The operating mode (normal or slow) that was in force on entry is frozen across the halt and restored on exit.

Any system reset ends the halt at once. Reset here means the combined pin, power-on and voltage-detect reset. After reset is released, a warm-up counter runs, and then the core is released in normal mode.

Top module: `tbt_halt_ctrl`

## Requirements
- R1: While reset is held, cpu_run, cpu_stop, wdt_stop, halt_bit, periph_stop_req and op_slow are 0 (op_slow 0 means normal mode). cpu_run first reads 1 exactly WARM_CYCLES+3 rising clock edges after rst_n goes high: 2 edges of reset synchronization, WARM_CYCLES edges of warm-up count, and 1 state update.
- R2: A halt_set strobe seen while the core runs sets halt_bit and raises periph_stop_req on the next edge, and cpu_run drops on that same edge.
- R3: cpu_stop and wdt_stop rise only on the edge after periph_stop_ack is seen high while the stop request is pending. Without the acknowledge they stay 0.
- R4: While halted with tbt_en=1, a falling edge of tbt_src_clk produces resume_valid exactly 3 edges after the input falls: 2 synchronizer flops and 1 state update.
- R5: While tbt_en is 0, falling edges of tbt_src_clk are ignored, and cpu_stop stays 1.
- R6: resume_irq equals ime AND tbt_ie as sampled on the waking edge. A value of 1 means interrupt release, and 0 means continue with the next instruction.
- R7: tbt_irq_set is a single-cycle pulse that coincides with resume_valid, and resume_valid also lasts one cycle.
- R8: halt_bit is already 0 while resume_valid is high, and cpu_run returns to 1 on the following edge.
- R9: op_slow follows mode_slow_in only while running. From the halt request through the exit cycle, it holds the mode captured on entry.
- R10: Asserting rst_n low during a halt drops cpu_stop, wdt_stop, periph_stop_req and halt_bit without waiting for a clock, and the full warm-up runs again.
- R11: A halt_set strobe during warm-up or during the exit cycle is ignored: halt_bit and periph_stop_req stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock that keeps toggling during the halt |
| rst_n | input | 1 | Combined active-low system reset (pin, power-on, voltage detect) |
| halt_set | input | 1 | One-cycle software write of 1 to the halt bit |
| periph_stop_ack | input | 1 | Peripherals report they have stopped |
| tbt_src_clk | input | 1 | Time-base timer source clock, asynchronous |
| tbt_en | input | 1 | Time-base timer enable |
| ime | input | 1 | Global interrupt master enable |
| tbt_ie | input | 1 | Per-source enable of the timer interrupt |
| mode_slow_in | input | 1 | Current operating mode from software, 1 = slow |
| cpu_run | output | 1 | Core may execute |
| cpu_stop | output | 1 | Core halted |
| wdt_stop | output | 1 | Watchdog halted |
| periph_stop_req | output | 1 | Request to stop peripherals, held through the halt |
| halt_bit | output | 1 | Readable halt-request bit, cleared by hardware on exit |
| resume_valid | output | 1 | One-cycle exit indication |
| resume_irq | output | 1 | Exit kind: 1 take interrupt, 0 next instruction |
| tbt_irq_set | output | 1 | One-cycle set pulse to the timer interrupt latch |
| op_slow | output | 1 | Operating mode in force, 1 = slow |

## Verification
The assertions assume two things about the inputs. First, tbt_src_clk stays in each level for several clk periods, so the two-flop synchronizer never misses an edge. Second, periph_stop_ack is driven only in answer to a pending stop request. The stimulus holds the timer clock steady for four cycles before each falling edge it drives. It raises the acknowledge for one cycle only, and only while the request is pending. A sweep covers all eight combinations of ime, tbt_ie and the entry mode through a full halt and wake cycle.

// File: rtl/tbt_halt_pkg.sv
`timescale 1ns/1ps
package tbt_halt_pkg;

  typedef enum logic [2:0] {
    ST_WARM  = 3'd0,
    ST_RUN   = 3'd1,
    ST_PSTOP = 3'd2,
    ST_HALT  = 3'd3,
    ST_EXIT  = 3'd4
  } halt_state_e;

  localparam int unsigned SYNC_MIN = 2;

endpackage

// File: rtl/tbt_rst_sync.sv
`timescale 1ns/1ps
module tbt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/tbt_fall_detect.sv
`timescale 1ns/1ps
module tbt_fall_detect
  import tbt_halt_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic fall
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  generate
    if (SYNC_STAGES < SYNC_MIN) begin : g_bad
      initial $fatal(1, "SYNC_STAGES below minimum");
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], async_in};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign fall = prev_q & ~sync_q[SYNC_STAGES-1];

  // a detected edge cannot repeat on the next cycle (R4)
  p_fall_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/tbt_warmup.sv
`timescale 1ns/1ps
module tbt_warmup #(
  parameter int unsigned WARM_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic count_en,
  output logic done
);
  localparam int unsigned CW = (WARM_CYCLES < 1) ? 1 : $clog2(WARM_CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign done   = (cnt_q == '0);
  assign cnt_en = count_en & ~done;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= CW'(WARM_CYCLES);
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // once expired the counter stays at zero until the next reset (R1)
  p_done_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
endmodule

// File: rtl/tbt_halt_fsm.sv
`timescale 1ns/1ps
module tbt_halt_fsm
  import tbt_halt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic warm_done,
  input  logic halt_set,
  input  logic periph_stop_ack,
  input  logic wake_fall,
  input  logic tbt_en,
  input  logic ime,
  input  logic tbt_ie,
  input  logic mode_slow_in,
  output logic warm_active,
  output logic cpu_run,
  output logic cpu_stop,
  output logic wdt_stop,
  output logic periph_stop_req,
  output logic halt_bit,
  output logic resume_valid,
  output logic resume_irq,
  output logic tbt_irq_set,
  output logic op_slow
);
  halt_state_e state_q, state_d;
  logic halt_q, halt_d;
  logic irq_q, irq_d;
  logic set_q, set_d;
  logic mode_q;
  logic mode_en;
  logic wake_ok;

  assign wake_ok = wake_fall & tbt_en;
  assign mode_en = (state_q == ST_RUN);

  always_comb begin
    state_d = state_q;
    halt_d  = halt_q;
    irq_d   = irq_q;
    set_d   = set_q;
    unique case (state_q)
      ST_WARM: begin
        if (warm_done) state_d = ST_RUN;
      end
      ST_RUN: begin
        if (halt_set) begin
          halt_d  = 1'b1;
          state_d = ST_PSTOP;
        end
      end
      ST_PSTOP: begin
        if (periph_stop_ack) state_d = ST_HALT;
      end
      ST_HALT: begin
        if (wake_ok) begin
          state_d = ST_EXIT;
          halt_d  = 1'b0;
          irq_d   = ime & tbt_ie;
          set_d   = tbt_en;
        end
      end
      ST_EXIT: begin
        state_d = ST_RUN;
        set_d   = 1'b0;
      end
      default: state_d = ST_WARM;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WARM;
      halt_q  <= 1'b0;
      irq_q   <= 1'b0;
      set_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      halt_q  <= halt_d;
      irq_q   <= irq_d;
      set_q   <= set_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= 1'b0;
    else if (mode_en) mode_q <= mode_slow_in;
  end

  assign warm_active     = (state_q == ST_WARM);
  assign cpu_run         = (state_q == ST_RUN);
  assign cpu_stop        = (state_q == ST_HALT);
  assign wdt_stop        = (state_q == ST_HALT);
  assign periph_stop_req = (state_q == ST_PSTOP) | (state_q == ST_HALT);
  assign halt_bit        = halt_q;
  assign resume_valid    = (state_q == ST_EXIT);
  assign resume_irq      = (state_q == ST_EXIT) & irq_q;
  assign tbt_irq_set     = (state_q == ST_EXIT) & set_q;
  assign op_slow         = mode_q;

  // halt is entered only after the peripherals acknowledged (R3)
  p_stop_after_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_stop) |-> $past(periph_stop_ack));

  // halt bit is only ever raised from the running state (R11)
  p_halt_from_run_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt_q) |-> $past(state_q == ST_RUN));

  // halt bit stays set while stopping and halted (R2)
  p_halt_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    periph_stop_req |-> halt_q);

  // an exit needs an enabled timer edge (R5)
  p_exit_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resume_valid) |-> $past(tbt_en && wake_fall));

  // halt bit is already clear during the exit cycle (R8)
  p_halt_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
    resume_valid |-> !halt_q);

  // exit lasts one cycle and returns to running (R7)
  p_exit_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    resume_valid |=> (cpu_run && !resume_valid && !tbt_irq_set));

  // saved mode cannot move while halted (R9)
  p_mode_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_stop && $past(cpu_stop)) |-> $stable(mode_q));
endmodule

// File: rtl/tbt_halt_ctrl.sv
`timescale 1ns/1ps
module tbt_halt_ctrl #(
  parameter int unsigned WARM_CYCLES = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic halt_set,
  input  logic periph_stop_ack,
  input  logic tbt_src_clk,
  input  logic tbt_en,
  input  logic ime,
  input  logic tbt_ie,
  input  logic mode_slow_in,
  output logic cpu_run,
  output logic cpu_stop,
  output logic wdt_stop,
  output logic periph_stop_req,
  output logic halt_bit,
  output logic resume_valid,
  output logic resume_irq,
  output logic tbt_irq_set,
  output logic op_slow
);
  logic rst_core_n;
  logic wake_fall;
  logic warm_done;
  logic warm_active;

  tbt_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  tbt_fall_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .async_in (tbt_src_clk),
    .fall     (wake_fall)
  );

  tbt_warmup #(.WARM_CYCLES(WARM_CYCLES)) u_warm (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .count_en (warm_active),
    .done     (warm_done)
  );

  tbt_halt_fsm u_fsm (
    .clk             (clk),
    .rst_n           (rst_core_n),
    .warm_done       (warm_done),
    .halt_set        (halt_set),
    .periph_stop_ack (periph_stop_ack),
    .wake_fall       (wake_fall),
    .tbt_en          (tbt_en),
    .ime             (ime),
    .tbt_ie          (tbt_ie),
    .mode_slow_in    (mode_slow_in),
    .warm_active     (warm_active),
    .cpu_run         (cpu_run),
    .cpu_stop        (cpu_stop),
    .wdt_stop        (wdt_stop),
    .periph_stop_req (periph_stop_req),
    .halt_bit        (halt_bit),
    .resume_valid    (resume_valid),
    .resume_irq      (resume_irq),
    .tbt_irq_set     (tbt_irq_set),
    .op_slow         (op_slow)
  );

  // the core never runs before the warm-up counter expires (R1)
  p_run_after_warm_r1: assert property (@(posedge clk) disable iff (!rst_core_n)
    cpu_run |-> warm_done);

  // CPU stop always comes with the peripheral stop request (R3)
  p_stop_with_req_r3: assert property (@(posedge clk) disable iff (!rst_core_n)
    cpu_stop |-> (periph_stop_req && wdt_stop && !cpu_run));
endmodule

// File: tb/tbt_halt_ctrl_test.sv
`timescale 1ns/1ps
module tbt_halt_ctrl_test;
  localparam int unsigned WARM = 16;

  logic clk = 1'b0;
  logic rst_n, halt_set, periph_stop_ack, tbt_src_clk, tbt_en, ime, tbt_ie, mode_slow_in;
  logic cpu_run, cpu_stop, wdt_stop, periph_stop_req, halt_bit;
  logic resume_valid, resume_irq, tbt_irq_set, op_slow;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  tbt_halt_ctrl #(.WARM_CYCLES(WARM)) uut (
    .clk(clk), .rst_n(rst_n), .halt_set(halt_set), .periph_stop_ack(periph_stop_ack),
    .tbt_src_clk(tbt_src_clk), .tbt_en(tbt_en), .ime(ime), .tbt_ie(tbt_ie),
    .mode_slow_in(mode_slow_in), .cpu_run(cpu_run), .cpu_stop(cpu_stop),
    .wdt_stop(wdt_stop), .periph_stop_req(periph_stop_req), .halt_bit(halt_bit),
    .resume_valid(resume_valid), .resume_irq(resume_irq), .tbt_irq_set(tbt_irq_set),
    .op_slow(op_slow)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic count_to_run(output int n);
    n = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      n++;
      if (cpu_run) break;
    end
  endtask

  task automatic enter_halt();
    halt_set = 1'b1;
    @(negedge clk);
    halt_set = 1'b0;
    periph_stop_ack = 1'b1;
    @(negedge clk);
    periph_stop_ack = 1'b0;
  endtask

  task automatic run_halt(input logic a_ime, input logic a_ie, input logic a_slow, input bit poke);
    int n;
    bit seen;
    ime = a_ime; tbt_ie = a_ie; mode_slow_in = a_slow; tbt_en = 1'b1; tbt_src_clk = 1'b1;
    repeat (4) @(negedge clk);
    chk(op_slow == a_slow, "R9 mode tracks while running", op_slow, a_slow);
    halt_set = 1'b1;
    @(negedge clk);
    halt_set = 1'b0;
    chk(halt_bit == 1'b1, "R2 halt_bit set", halt_bit, 1);
    chk(periph_stop_req == 1'b1, "R2 stop request", periph_stop_req, 1);
    chk(cpu_run == 1'b0, "R2 cpu_run drops", cpu_run, 0);
    repeat (2) @(negedge clk);
    chk(cpu_stop == 1'b0, "R3 no halt without ack", cpu_stop, 0);
    periph_stop_ack = 1'b1;
    @(negedge clk);
    periph_stop_ack = 1'b0;
    chk(cpu_stop && wdt_stop, "R3 halted after ack", cpu_stop & wdt_stop, 1);
    mode_slow_in = ~a_slow;
    repeat (2) @(negedge clk);
    chk(op_slow == a_slow, "R9 mode frozen in halt", op_slow, a_slow);
    tbt_src_clk = 1'b0;
    n = 0; seen = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      n++;
      if (resume_valid) begin seen = 1; break; end
    end
    chk(seen && n == 3, "R4 wake latency", n, 3);
    chk(resume_irq == (a_ime & a_ie), "R6 resume kind", resume_irq, a_ime & a_ie);
    chk(tbt_irq_set == 1'b1, "R7 latch set pulse", tbt_irq_set, 1);
    chk(halt_bit == 1'b0, "R8 halt bit cleared", halt_bit, 0);
    chk(op_slow == a_slow, "R9 mode restored", op_slow, a_slow);
    if (poke) halt_set = 1'b1;
    @(negedge clk);
    halt_set = 1'b0;
    chk(!resume_valid && !tbt_irq_set, "R7 single-cycle pulses", resume_valid + tbt_irq_set, 0);
    chk(cpu_run == 1'b1, "R8 running again", cpu_run, 1);
    if (poke) begin
      chk(!halt_bit && !periph_stop_req, "R11 halt ignored at exit", halt_bit + periph_stop_req, 0);
      @(negedge clk);
      chk(!periph_stop_req && cpu_run, "R11 still running", periph_stop_req, 0);
    end
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    bit seen;
    rst_n = 1'b0; halt_set = 1'b0; periph_stop_ack = 1'b0; tbt_src_clk = 1'b0;
    tbt_en = 1'b0; ime = 1'b0; tbt_ie = 1'b0; mode_slow_in = 1'b0;
    repeat (3) @(negedge clk);
    chk(!cpu_run && !cpu_stop && !wdt_stop && !halt_bit && !periph_stop_req && !op_slow,
        "R1 reset state", cpu_run + cpu_stop + halt_bit + periph_stop_req + op_slow, 0);
    rst_n = 1'b1;
    count_to_run(n);
    chk(n == WARM + 3, "R1 warm-up length", n, WARM + 3);

    for (int k = 0; k < 8; k++)
      run_halt(logic'(k & 1), logic'((k >> 1) & 1), logic'((k >> 2) & 1), k == 7);

    // R5: timer disabled, edges ignored
    tbt_en = 1'b0; tbt_src_clk = 1'b1;
    repeat (4) @(negedge clk);
    enter_halt();
    tbt_src_clk = 1'b0;
    seen = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (resume_valid) seen = 1;
    end
    chk(cpu_stop && !seen, "R5 disabled edge ignored", cpu_stop, 1);
    tbt_src_clk = 1'b1;
    repeat (4) @(negedge clk);
    tbt_en = 1'b1; tbt_src_clk = 1'b0;
    seen = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (resume_valid) begin seen = 1; break; end
    end
    chk(seen, "R5 wake once enabled", seen, 1);
    @(negedge clk);

    // R10: reset during halt
    tbt_src_clk = 1'b1;
    repeat (4) @(negedge clk);
    enter_halt();
    chk(cpu_stop == 1'b1, "R10 halted before reset", cpu_stop, 1);
    rst_n = 1'b0;
    #1;
    chk(!cpu_stop && !wdt_stop && !periph_stop_req && !halt_bit, "R10 reset ends halt",
        cpu_stop + periph_stop_req + halt_bit, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    n = 0;
    for (int i = 0; i < 100; i++) begin
      halt_set = (i == 4);
      @(negedge clk);
      n++;
      if (cpu_run) break;
    end
    halt_set = 1'b0;
    chk(n == WARM + 3, "R10 warm-up repeated", n, WARM + 3);
    repeat (3) @(negedge clk);
    chk(!halt_bit && !periph_stop_req && cpu_run, "R11 halt ignored in warm-up",
        halt_bit + periph_stop_req, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule